// File: doc/BRIEF.md
# Strobe-Handshake Host Register Interface

This block sits between a parallel host bus and a serial link engine. The host makes every access with one strobe line and gets back one FULL status line. A read/write select picks the direction. A register select picks either the data path (the transmit and receive holding registers) or the configuration side: a small control register on writes, and a status word on reads that returns the control bits together with three sticky transmission-error flags. Each access takes effect on the rising edge of the strobe. Holding the strobe high does not repeat the access.

On the engine side the block presents the word waiting to be sent, with a valid flag that the engine drops through a take pulse. It accepts received words through a push pulse and collects error pulses from the engine. It also drives the width mode, the timeout-disable setting and an engine-clear level. The clear level comes from an active-low run bit. After reset that bit is 0, so the engine stays held until the host writes the bit to 1. Writing the bit to 0 later drops any pending words and clears the error flags. The data bus is modelled as a read-data bus with an output enable, and the host signals are taken as synchronous to the clock.

Top module: `strobe_host_regif`

## Requirements
- R1: After reset, full_o and error_o are 0, engine_clr_o is 1, and a status read returns 0.
- R2: A data write (strobe rising with rd_wr_i=0, reg_sel_i=1) while running loads the transmit word. tx_valid_o and full_o are 1 from the next cycle until a tx_take_i pulse.
- R3: With the width bit at 0 (16-bit mode), bits 31:16 of a written transmit word and of a returned receive word are 0. Only bits 15:0 pass.
- R4: A data read (rd_wr_i=1, reg_sel_i=1) puts the waiting received word on host_rdata_o from the cycle after the strobe rising edge. host_oe_o is high while strobe and read are both high. The receive word is released, so full_o drops, at that edge.
- R5: A control write (rd_wr_i=0, reg_sel_i=0) takes bit 0 as timeout-disable (ign_timeout_o), bit 1 as the width bit (mode32_o, 1 = 32-bit) and bit 2 as the active-low clear (run=1). engine_clr_o equals the inverse of bit 2. Other written bits have no effect.
- R6: A status read (rd_wr_i=1, reg_sel_i=0) returns bits 2:0 as the control bits above, bit 3 overwrite, bit 4 word-missing and bit 5 sync-missing. All other bits read 0.
- R7: A push while a received word is still unread and link_active_i=1 sets the overwrite flag. With link_active_i=0 (idle) the flag is not set.
- R8: Pulses on err_word_miss_i and err_sync_miss_i set their sticky flags. error_o is the OR of the three flags. A control write that keeps bit 2 at 1 leaves the flags set.
- R9: A control write with bit 2 at 0 clears all error flags and both pending words. While bit 2 is 0, data writes, pushes and error pulses are ignored, and full_o stays 0.
- R10: A strobe held high makes exactly one access. It does not reload the transmit word after a take.
- R11: A push on the same edge as a data read keeps the new word (full_o stays 1), returns the old word and raises no overwrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_i | input | 1 | Host strobe; an access happens on its rising edge |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| reg_sel_i | input | 1 | 1 = data registers, 0 = control/status |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data |
| host_oe_o | output | 1 | Read-data output enable |
| full_o | output | 1 | A transmit or receive word is pending |
| error_o | output | 1 | OR of the sticky error flags |
| tx_data_o | output | DW | Word waiting to be sent |
| tx_valid_o | output | 1 | Transmit word pending |
| tx_take_i | input | 1 | Engine has taken the transmit word |
| rx_push_i | input | 1 | Engine delivers a received word |
| rx_data_i | input | DW | Received word |
| link_active_i | input | 1 | Engine is out of idle |
| err_word_miss_i | input | 1 | Word-missing error pulse |
| err_sync_miss_i | input | 1 | Sync-bit-missing error pulse |
| mode32_o | output | 1 | 1 = 32-bit host width |
| ign_timeout_o | output | 1 | Transmit timeout disabled |
| engine_clr_o | output | 1 | Engine held in clear |

## Verification
The data path is exercised with full-width words in 32-bit mode and with words whose upper half is non-zero in 16-bit mode. These two patterns separate correct truncation from pass-through. Received words are pushed in three ways: read between pushes, pushed twice with the link active, and pushed twice with the link idle. Comparing these isolates the overwrite condition from plain reception. A push that coincides with a read shows which of the two wins. The strobe is held high across an engine take to show that the access fires only once. Control writes are made both with and without the clear bit, so that clearing and stickiness are told apart. A behavioural model is compared with the outputs on every clock.

// File: rtl/hif_pkg.sv
package hif_pkg;
  // Control and status bit positions visible to the host
  localparam int CTL_IGN_BIT  = 0;
  localparam int CTL_WIDE_BIT = 1;
  localparam int CTL_RUN_BIT  = 2;
  localparam int ST_OVW_BIT   = 3;
  localparam int ST_WMISS_BIT = 4;
  localparam int ST_SYNC_BIT  = 5;
  localparam int CTL_W        = 3;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_WR_DATA,
    ACC_WR_CTL,
    ACC_RD_DATA,
    ACC_RD_STAT
  } acc_e;

  typedef struct packed {
    logic run;
    logic wide;
    logic ign;
  } ctl_t;

  typedef struct packed {
    logic sync_miss;
    logic word_miss;
    logic overwrite;
  } err_t;
endpackage

// File: rtl/hif_strobe_decode.sv
module hif_strobe_decode
  import hif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strb_i,
  input  logic rd_wr_i,
  input  logic reg_sel_i,
  output acc_e acc_o
);
  logic strb_d_q;
  logic strb_d_nxt;
  logic strb_rise;

  assign strb_d_nxt = strb_i;
  assign strb_rise  = strb_i & ~strb_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_d_q <= 1'b0;
    else        strb_d_q <= strb_d_nxt;
  end

  always_comb begin
    acc_o = ACC_NONE;
    if (strb_rise) begin
      case ({rd_wr_i, reg_sel_i})
        2'b01:   acc_o = ACC_WR_DATA;
        2'b00:   acc_o = ACC_WR_CTL;
        2'b11:   acc_o = ACC_RD_DATA;
        default: acc_o = ACC_RD_STAT;
      endcase
    end
  end
endmodule

// File: rtl/hif_ctrl_regs.sv
module hif_ctrl_regs
  import hif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  acc_e             acc_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             ovw_evt_i,
  input  logic             err_word_miss_i,
  input  logic             err_sync_miss_i,
  output ctl_t             ctl_o,
  output err_t             err_o,
  output logic             clr_now_o,
  output logic             error_o
);
  ctl_t ctl_q, ctl_nxt;
  err_t err_q, err_nxt;
  logic ctl_we;
  logic err_en;
  err_t err_set;

  assign ctl_we    = (acc_i == ACC_WR_CTL);
  assign clr_now_o = ctl_we & ~wdata_i[CTL_RUN_BIT];

  assign err_set.overwrite = ovw_evt_i;
  assign err_set.word_miss = err_word_miss_i;
  assign err_set.sync_miss = err_sync_miss_i;

  always_comb begin
    ctl_nxt = ctl_q;
    if (ctl_we) begin
      ctl_nxt.run  = wdata_i[CTL_RUN_BIT];
      ctl_nxt.wide = wdata_i[CTL_WIDE_BIT];
      ctl_nxt.ign  = wdata_i[CTL_IGN_BIT];
    end
  end

  // Flags collect only while running; a clear write wins over any set
  assign err_en = clr_now_o | ctl_q.run;

  always_comb begin
    if (clr_now_o) err_nxt = '0;
    else           err_nxt = err_q | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (err_en) begin
      err_q <= err_nxt;
    end
  end

  assign ctl_o   = ctl_q;
  assign err_o   = err_q;
  assign error_o = |err_q;
endmodule

// File: rtl/hif_data_regs.sv
module hif_data_regs
  import hif_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_e          acc_i,
  input  logic [DW-1:0] wdata_i,
  input  ctl_t          ctl_i,
  input  logic          clr_now_i,
  input  logic [SW-1:0] status_i,
  input  logic          tx_take_i,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          link_active_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  output logic          rx_full_o,
  output logic [DW-1:0] rdata_o,
  output logic          ovw_evt_o
);
  localparam int HALF = DW / 2;
  localparam int UPW  = DW - HALF;

  logic [DW-1:0] tx_data_q, tx_data_nxt;
  logic [DW-1:0] rx_data_q;
  logic [DW-1:0] rdata_q, rdata_nxt;
  logic          tx_full_q, tx_full_nxt;
  logic          rx_full_q, rx_full_nxt;
  logic          tx_data_en, rx_data_en, rdata_en;
  logic          wr_data, rd_data, rd_stat, drop;

  function automatic logic [DW-1:0] fit_width(input logic [DW-1:0] d, input logic wide);
    return wide ? d : {{UPW{1'b0}}, d[HALF-1:0]};
  endfunction

  assign wr_data = (acc_i == ACC_WR_DATA);
  assign rd_data = (acc_i == ACC_RD_DATA);
  assign rd_stat = (acc_i == ACC_RD_STAT);
  assign drop    = ~ctl_i.run | clr_now_i;

  // Transmit holding register
  assign tx_data_en  = wr_data & ctl_i.run;
  assign tx_data_nxt = fit_width(wdata_i, ctl_i.wide);

  always_comb begin
    if (drop)           tx_full_nxt = 1'b0;
    else if (wr_data)   tx_full_nxt = 1'b1;
    else if (tx_take_i) tx_full_nxt = 1'b0;
    else                tx_full_nxt = tx_full_q;
  end

  // Receive holding register; a push beats a release on the same edge
  assign rx_data_en = rx_push_i & ~drop;

  always_comb begin
    if (drop)           rx_full_nxt = 1'b0;
    else if (rx_push_i) rx_full_nxt = 1'b1;
    else if (rd_data)   rx_full_nxt = 1'b0;
    else                rx_full_nxt = rx_full_q;
  end

  assign ovw_evt_o = ~drop & rx_push_i & rx_full_q & ~rd_data & link_active_i;

  // Read data latch, captured at the strobe edge
  assign rdata_en = rd_data | rd_stat;

  always_comb begin
    if (rd_data) rdata_nxt = fit_width(rx_data_q, ctl_i.wide);
    else         rdata_nxt = {{(DW-SW){1'b0}}, status_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
    end else begin
      tx_full_q <= tx_full_nxt;
      rx_full_q <= rx_full_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_data_q <= '0;
    else if (tx_data_en) tx_data_q <= tx_data_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_data_q <= '0;
    else if (rx_data_en) rx_data_q <= rx_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_nxt;
  end

  assign tx_data_o  = tx_data_q;
  assign tx_valid_o = tx_full_q;
  assign rx_full_o  = rx_full_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/strobe_host_regif.sv
module strobe_host_regif
  import hif_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb_i,
  input  logic          rd_wr_i,
  input  logic          reg_sel_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          host_oe_o,
  output logic          full_o,
  output logic          error_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_take_i,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          link_active_i,
  input  logic          err_word_miss_i,
  input  logic          err_sync_miss_i,
  output logic          mode32_o,
  output logic          ign_timeout_o,
  output logic          engine_clr_o
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  acc_e                  acc;
  ctl_t                  ctl;
  err_t                  err;
  logic                  clr_now;
  logic                  ovw_evt;
  logic                  rx_full;
  logic [SW-1:0]         status;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  hif_strobe_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .strb_i    (strb_i),
    .rd_wr_i   (rd_wr_i),
    .reg_sel_i (reg_sel_i),
    .acc_o     (acc)
  );

  hif_ctrl_regs u_ctrl (
    .clk             (clk),
    .rst_n           (rst_int_n),
    .acc_i           (acc),
    .wdata_i         (host_wdata_i[CTL_W-1:0]),
    .ovw_evt_i       (ovw_evt),
    .err_word_miss_i (err_word_miss_i),
    .err_sync_miss_i (err_sync_miss_i),
    .ctl_o           (ctl),
    .err_o           (err),
    .clr_now_o       (clr_now),
    .error_o         (error_o)
  );

  always_comb begin
    status               = '0;
    status[CTL_IGN_BIT]  = ctl.ign;
    status[CTL_WIDE_BIT] = ctl.wide;
    status[CTL_RUN_BIT]  = ctl.run;
    status[ST_OVW_BIT]   = err.overwrite;
    status[ST_WMISS_BIT] = err.word_miss;
    status[ST_SYNC_BIT]  = err.sync_miss;
  end

  hif_data_regs #(.DW(DW), .SW(SW)) u_data (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .acc_i         (acc),
    .wdata_i       (host_wdata_i),
    .ctl_i         (ctl),
    .clr_now_i     (clr_now),
    .status_i      (status),
    .tx_take_i     (tx_take_i),
    .rx_push_i     (rx_push_i),
    .rx_data_i     (rx_data_i),
    .link_active_i (link_active_i),
    .tx_data_o     (tx_data_o),
    .tx_valid_o    (tx_valid_o),
    .rx_full_o     (rx_full),
    .rdata_o       (host_rdata_o),
    .ovw_evt_o     (ovw_evt)
  );

  assign full_o        = tx_valid_o | rx_full;
  assign host_oe_o     = strb_i & rd_wr_i;
  assign mode32_o      = ctl.wide;
  assign ign_timeout_o = ctl.ign;
  assign engine_clr_o  = ~ctl.run;
endmodule

// File: rtl/hif_checker.sv
module hif_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strb_i,
  input logic          rd_wr_i,
  input logic          reg_sel_i,
  input logic [DW-1:0] host_wdata_i,
  input logic          full_o,
  input logic          error_o,
  input logic [DW-1:0] tx_data_o,
  input logic          tx_valid_o,
  input logic          rx_push_i,
  input logic          mode32_o,
  input logic          engine_clr_o
);
  localparam int HALF = DW / 2;

  logic strb_q;
  logic rise, wr_data_evt, rd_data_evt, clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= strb_i;
  end

  assign rise        = strb_i & ~strb_q;
  assign wr_data_evt = rise & ~rd_wr_i & reg_sel_i;
  assign rd_data_evt = rise & rd_wr_i & reg_sel_i;
  assign clr_evt     = rise & ~rd_wr_i & ~reg_sel_i & ~host_wdata_i[2];

  a_r2_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_evt && !engine_clr_o) |=> tx_valid_o);

  a_r9_held_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
    engine_clr_o |-> !full_o);

  a_r4_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_evt && !rx_push_i && !tx_valid_o) |=> !full_o);

  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (error_o && !clr_evt) |=> error_o);

  a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_valid_o) && !mode32_o) |-> (tx_data_o[DW-1:HALF] == '0));

  a_r10_level_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_i && strb_q && !tx_valid_o) |=> !tx_valid_o);
endmodule

bind strobe_host_regif hif_checker #(.DW(DW)) u_hif_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .strb_i       (strb_i),
  .rd_wr_i      (rd_wr_i),
  .reg_sel_i    (reg_sel_i),
  .host_wdata_i (host_wdata_i),
  .full_o       (full_o),
  .error_o      (error_o),
  .tx_data_o    (tx_data_o),
  .tx_valid_o   (tx_valid_o),
  .rx_push_i    (rx_push_i),
  .mode32_o     (mode32_o),
  .engine_clr_o (engine_clr_o)
);

// File: tb/strobe_host_regif_bench.sv
module strobe_host_regif_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          strb, rd_wr, reg_sel;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          oe, full, error;
  logic [DW-1:0] tx_data;
  logic          tx_valid, tx_take, rx_push;
  logic [DW-1:0] rx_data;
  logic          link_active, wmiss, smiss;
  logic          mode32, ign, eclr;

  strobe_host_regif #(.DW(DW)) u_strobe_host_regif (
    .clk(clk), .rst_n(rst_n), .strb_i(strb), .rd_wr_i(rd_wr), .reg_sel_i(reg_sel),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .host_oe_o(oe), .full_o(full),
    .error_o(error), .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_take_i(tx_take),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .link_active_i(link_active),
    .err_word_miss_i(wmiss), .err_sync_miss_i(smiss), .mode32_o(mode32),
    .ign_timeout_o(ign), .engine_clr_o(eclr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit            m_strb_d, m_run, m_wide, m_ign, m_ovw, m_wm, m_sm, m_txf, m_rxf;
  logic [DW-1:0] m_txd, m_rxd, m_rd;

  function automatic logic [DW-1:0] half_cut(input logic [DW-1:0] d, input bit wide);
    return wide ? d : (d & 32'h0000_FFFF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_strb_d = 0; m_run = 0; m_wide = 0; m_ign = 0;
      m_ovw = 0; m_wm = 0; m_sm = 0; m_txf = 0; m_rxf = 0;
      m_txd = '0; m_rxd = '0; m_rd = '0;
    end else begin
      bit ev, wrd, wrc, rdd, rds, clr, ovw_now;
      ev  = strb && !m_strb_d;
      m_strb_d = strb;
      wrd = ev && !rd_wr && reg_sel;
      wrc = ev && !rd_wr && !reg_sel;
      rdd = ev && rd_wr && reg_sel;
      rds = ev && rd_wr && !reg_sel;
      clr = wrc && !wdata[2];
      if (rdd) m_rd = half_cut(m_rxd, m_wide);
      else if (rds) m_rd = {26'd0, m_sm, m_wm, m_ovw, m_run, m_wide, m_ign};
      ovw_now = m_run && !clr && rx_push && m_rxf && !rdd && link_active;
      if (!m_run || clr) m_txf = 0;
      else if (wrd) begin m_txf = 1; m_txd = half_cut(wdata, m_wide); end
      else if (tx_take) m_txf = 0;
      if (!m_run || clr) m_rxf = 0;
      else if (rx_push) begin m_rxf = 1; m_rxd = rx_data; end
      else if (rdd) m_rxf = 0;
      if (clr) begin m_ovw = 0; m_wm = 0; m_sm = 0; end
      else if (m_run) begin
        m_ovw = m_ovw | ovw_now;
        m_wm  = m_wm | wmiss;
        m_sm  = m_sm | smiss;
      end
      if (wrc) begin m_run = wdata[2]; m_wide = wdata[1]; m_ign = wdata[0]; end
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 tx_valid", tx_valid, m_txf);
      check("R4 full", full, m_txf | m_rxf);
      check("R8 error", error, m_ovw | m_wm | m_sm);
      check("R5 mode32", mode32, m_wide);
      check("R5 ign_timeout", ign, m_ign);
      check("R9 engine_clr", eclr, !m_run);
      check("R6 rdata", rdata, m_rd);
      if (m_txf) check("R3 tx_data", tx_data, m_txd);
    end
  end

  task automatic host_wr(input bit sel, input logic [DW-1:0] w, input int hold = 1);
    @(negedge clk);
    strb = 1; rd_wr = 0; reg_sel = sel; wdata = w;
    repeat (hold) @(negedge clk);
    strb = 0;
    @(negedge clk);
  endtask

  task automatic host_rd(input bit sel, output logic [DW-1:0] d, output logic o);
    @(negedge clk);
    strb = 1; rd_wr = 1; reg_sel = sel;
    @(negedge clk);
    #1; d = rdata; o = oe;
    strb = 0;
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk);
    rx_push = 1; rx_data = d;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    logic          o;
    rst_n = 0; strb = 0; rd_wr = 0; reg_sel = 0; wdata = '0;
    tx_take = 0; rx_push = 0; rx_data = '0; link_active = 0; wmiss = 0; smiss = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 full", full, 0);
    check("R1 error", error, 0);
    check("R1 engine_clr", eclr, 1);
    host_rd(0, d, o);
    check("R1 status", d, 0);

    // R5 control bits, R6 status layout
    host_wr(0, 32'hFFFF_FFF7);
    check("R5 mode32", mode32, 1);
    check("R5 ign", ign, 1);
    check("R5 engine_clr", eclr, 0);
    host_rd(0, d, o);
    check("R6 status", d, 32'h7);

    // R2 write; R10 strobe held across take
    @(negedge clk);
    strb = 1; rd_wr = 0; reg_sel = 1; wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R2 valid", tx_valid, 1);
    check("R2 full", full, 1);
    check("R2 data", tx_data, 32'hDEAD_BEEF);
    tx_take = 1;
    @(negedge clk);
    tx_take = 0;
    repeat (3) @(negedge clk);
    check("R10 no reload", tx_valid, 0);
    strb = 0;
    @(negedge clk);

    // R4 read path
    link_active = 1;
    push(32'h1234_5678);
    check("R4 full after push", full, 1);
    host_rd(1, d, o);
    check("R4 rdata", d, 32'h1234_5678);
    check("R4 oe", o, 1);
    check("R4 full released", full, 0);
    check("R4 oe low", oe, 0);

    // R11 push coincident with read
    push(32'h0000_0A0A);
    @(negedge clk);
    strb = 1; rd_wr = 1; reg_sel = 1; rx_push = 1; rx_data = 32'h0000_0B0B;
    @(negedge clk);
    rx_push = 0;
    check("R11 old word", rdata, 32'h0000_0A0A);
    check("R11 full kept", full, 1);
    check("R11 no overwrite", error, 0);
    strb = 0;
    @(negedge clk);
    host_rd(1, d, o);
    check("R11 new word", d, 32'h0000_0B0B);

    // R7 overwrite with link active
    push(32'h1);
    push(32'h2);
    check("R7 overwrite error", error, 1);
    host_rd(0, d, o);
    check("R7 status bit3", d[3], 1);

    // R9 clear write, then held engine ignores everything
    host_wr(0, 32'h3);
    check("R9 error cleared", error, 0);
    check("R9 full cleared", full, 0);
    push(32'h55);
    @(negedge clk); wmiss = 1; @(negedge clk); wmiss = 0;
    host_wr(1, 32'h77);
    check("R9 full held", full, 0);
    check("R9 error held", error, 0);

    // R3 16-bit mode
    host_wr(0, 32'h5);
    host_wr(1, 32'hCAFE_F00D);
    check("R3 tx upper cut", tx_data, 32'h0000_F00D);
    @(negedge clk); tx_take = 1; @(negedge clk); tx_take = 0;
    push(32'hAAAA_5555);
    host_rd(1, d, o);
    check("R3 rx upper cut", d, 32'h0000_5555);

    // R7 idle link: no overwrite
    link_active = 0;
    push(32'h9);
    push(32'hA);
    check("R7 idle no overwrite", error, 0);
    host_rd(1, d, o);
    check("R7 idle latest word", d, 32'hA);

    // R8 sticky flags
    @(negedge clk); wmiss = 1; @(negedge clk); wmiss = 0;
    check("R8 word miss", error, 1);
    @(negedge clk); smiss = 1; @(negedge clk); smiss = 0;
    host_rd(0, d, o);
    check("R8 status flags", d[5:4], 2'b11);
    host_wr(0, 32'h7);
    check("R8 kept after run write", error, 1);
    host_wr(0, 32'h3);
    check("R8 cleared", error, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule